// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. It steps through a fetch, decode and execute loop, and it reaches instructions and data in a single word-addressed memory of 4096 sixteen-bit words. All arithmetic uses 16-bit two's complement and wraps on overflow. Every memory access goes through two internal registers: an address register that drives the memory address port, and a buffer register that holds the word read from memory or the word to be written to it.

The memory outside the core is synchronous. It captures the address on one rising edge and returns the read data after that edge. It writes `mem_wdata` at `mem_addr` on any edge where `mem_we` is high. Because of this, each read takes an address cycle, a wait cycle and a capture cycle.

The core has an 8-bit input port that is sampled into an input register and an 8-bit output port with a one-cycle strobe. A halt instruction stops the core until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `halted`, `mem_we` and `io_out_stb` are 0, `io_out` is 0x00 and `mem_addr` is 0. After reset the first instruction is fetched from address 0.
- R2: An instruction word carries its opcode in bits 15..12 and an operand address X in bits 11..0. Instructions run in ascending address order unless a jump or skip changes the order.
- R3: Opcode 1 loads the word at X into the accumulator. Opcode 2 writes the accumulator to X, with `mem_we` high for exactly one cycle.
- R4: Opcode 3 adds the word at X to the accumulator and opcode 4 subtracts it. Both wrap modulo 2^16, so 0x0023 plus 0xFFE9 gives 0x000C.
- R5: Opcode 8 skips the next instruction when the test chosen by bits 11..10 holds. 00 tests accumulator negative, 01 tests zero, 10 tests strictly positive, and 11 never skips.
- R6: Opcode 9 continues at X. Opcode C continues at the address held in bits 11..0 of the word at X.
- R7: Opcode B reads the word at X, uses its bits 11..0 as a second address, and adds the word at that second address to the accumulator.
- R8: Opcode 0 writes the address of the following instruction, zero-extended, to X and continues at X+1.
- R9: Opcode 5 loads the input port value, zero-extended, into the accumulator. Opcode A sets the accumulator to zero.
- R10: Opcode 6 places accumulator bits 7..0 on `io_out` and raises `io_out_stb` for one cycle. `io_out` changes only together with the strobe.
- R11: Opcode 7 raises `halted`, which stays high until reset. No instruction after the halt runs and `mem_we` stays low.
- R12: Opcodes D, E and F change no register or memory word. Execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_we | output | 1 | Write enable, one cycle per store |
| mem_rdata | input | 16 | Read data, valid the cycle after the address is captured |
| io_in | input | 8 | Input port value |
| io_out | output | 8 | Output port value |
| io_out_stb | output | 1 | One-cycle pulse when `io_out` is updated |
| halted | output | 1 | High once the core has stopped |

## Verification
The situations hardest to reach from the ports are the two-level read of the indirect add and the return linkage of jump-and-store. In both, the result depends on a word the core wrote or read earlier in the same program.

The bench builds programs where a pointer word selects an operand in another region. It also builds a subroutine that reads back its own stored return address, jumps through it indirectly, and then proves that the caller continued.

The skip tests are swept over every condition code against boundary values such as 0x7FFF, 0x8000, 0 and 0xFFFF. The input port is swept over all 256 values.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OP_JNS    = 4'h0;
  localparam logic [3:0] OP_LOAD   = 4'h1;
  localparam logic [3:0] OP_STORE  = 4'h2;
  localparam logic [3:0] OP_ADD    = 4'h3;
  localparam logic [3:0] OP_SUBT   = 4'h4;
  localparam logic [3:0] OP_INPUT  = 4'h5;
  localparam logic [3:0] OP_OUTPUT = 4'h6;
  localparam logic [3:0] OP_HALT   = 4'h7;
  localparam logic [3:0] OP_SKIP   = 4'h8;
  localparam logic [3:0] OP_JUMP   = 4'h9;
  localparam logic [3:0] OP_CLEAR  = 4'hA;
  localparam logic [3:0] OP_ADDI   = 4'hB;
  localparam logic [3:0] OP_JUMPI  = 4'hC;

  typedef enum logic [3:0] {
    S_FETCH0,
    S_FETCH1,
    S_FETCH2,
    S_DECODE,
    S_RD1,
    S_RD2,
    S_EXEC,
    S_WR,
    S_HALT
  } cpu_state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD: y = acc + opnd;
      ALU_SUB: y = acc - opnd;
      default: y = opnd;
    endcase
  end

endmodule

// File: rtl/acc_cpu_skip.sv
module acc_cpu_skip #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] acc,
  input  logic [1:0]    sel,
  output logic          take
);

  logic is_neg, is_zero;

  assign is_neg  = acc[DW-1];
  assign is_zero = (acc == '0);

  always_comb begin
    case (sel)
      2'b00:   take = is_neg;
      2'b01:   take = is_zero;
      2'b10:   take = !is_neg && !is_zero;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int IOW = 8
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_we,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [IOW-1:0] io_in,
  output logic [IOW-1:0] io_out,
  output logic           io_out_stb,
  output logic           halted
);

  localparam int OPW = DW - AW;
  localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};

  cpu_state_e     st_q;
  logic [AW-1:0]  pc_q, mar_q;
  logic [DW-1:0]  ac_q, ir_q, mbr_q;
  logic [IOW-1:0] in_q, out_q;
  logic           ind_q, we_q, stb_q, halt_q;

  logic [OPW-1:0] opcode;
  logic [AW-1:0]  operand;
  logic [1:0]     skip_sel;
  logic           skip_take;
  alu_op_e        alu_op;
  logic [DW-1:0]  alu_y;

  assign opcode   = ir_q[DW-1 -: OPW];
  assign operand  = ir_q[AW-1:0];
  assign skip_sel = ir_q[AW-1 -: 2];

  always_comb begin
    case (opcode)
      OP_LOAD: alu_op = ALU_PASS;
      OP_SUBT: alu_op = ALU_SUB;
      default: alu_op = ALU_ADD;
    endcase
  end

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op   (alu_op),
    .acc  (ac_q),
    .opnd (mbr_q),
    .y    (alu_y)
  );

  acc_cpu_skip #(.DW(DW)) u_skip (
    .acc  (ac_q),
    .sel  (skip_sel),
    .take (skip_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_FETCH0;
      pc_q   <= '0;
      mar_q  <= '0;
      ac_q   <= '0;
      ir_q   <= '0;
      mbr_q  <= '0;
      in_q   <= '0;
      out_q  <= '0;
      ind_q  <= 1'b0;
      we_q   <= 1'b0;
      stb_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      in_q  <= io_in;
      stb_q <= 1'b0;
      case (st_q)
        S_FETCH0: begin
          mar_q <= pc_q;
          st_q  <= S_FETCH1;
        end
        S_FETCH1: st_q <= S_FETCH2;
        S_FETCH2: begin
          mbr_q <= mem_rdata;
          ir_q  <= mem_rdata;
          pc_q  <= pc_q + PC_ONE;
          st_q  <= S_DECODE;
        end
        S_DECODE: begin
          mar_q <= operand;
          ind_q <= 1'b0;
          st_q  <= S_FETCH0;
          case (opcode)
            OP_LOAD, OP_ADD, OP_SUBT, OP_ADDI, OP_JUMPI: st_q <= S_RD1;
            OP_STORE: begin
              mbr_q <= ac_q;
              we_q  <= 1'b1;
              st_q  <= S_WR;
            end
            OP_JNS: begin
              mbr_q <= {{OPW{1'b0}}, pc_q};
              we_q  <= 1'b1;
              st_q  <= S_WR;
            end
            OP_INPUT:  ac_q <= {{(DW-IOW){1'b0}}, in_q};
            OP_OUTPUT: begin
              out_q <= ac_q[IOW-1:0];
              stb_q <= 1'b1;
            end
            OP_HALT: begin
              halt_q <= 1'b1;
              st_q   <= S_HALT;
            end
            OP_SKIP:  if (skip_take) pc_q <= pc_q + PC_ONE;
            OP_JUMP:  pc_q <= operand;
            OP_CLEAR: ac_q <= '0;
            default: ;
          endcase
        end
        S_RD1: st_q <= S_RD2;
        S_RD2: begin
          mbr_q <= mem_rdata;
          st_q  <= S_EXEC;
        end
        S_EXEC: begin
          st_q <= S_FETCH0;
          case (opcode)
            OP_JUMPI: pc_q <= mbr_q[AW-1:0];
            OP_ADDI: begin
              if (!ind_q) begin
                mar_q <= mbr_q[AW-1:0];
                ind_q <= 1'b1;
                st_q  <= S_RD1;
              end else begin
                ac_q  <= alu_y;
                ind_q <= 1'b0;
              end
            end
            default: ac_q <= alu_y;
          endcase
        end
        S_WR: begin
          we_q <= 1'b0;
          if (opcode == OP_JNS) pc_q <= mar_q + PC_ONE;
          st_q <= S_FETCH0;
        end
        default: st_q <= S_HALT;
      endcase
    end
  end

  assign mem_addr   = mar_q;
  assign mem_wdata  = mbr_q;
  assign mem_we     = we_q;
  assign io_out     = out_q;
  assign io_out_stb = stb_q;
  assign halted     = halt_q;

  p_stb_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    io_out_stb |=> !io_out_stb);

  p_out_with_stb_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(io_out) |-> io_out_stb);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_FETCH2) |=> (pc_q == $past(pc_q) + PC_ONE));

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic [7:0]  io_in = 8'h00;
  logic [7:0]  io_out;
  logic        io_out_stb;
  logic        halted;

  logic [15:0] mem [256];
  int checks = 0;
  int fails  = 0;
  int stb_cnt = 0;

  always #10 clk = ~clk;

  acc_cpu_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_rdata  (mem_rdata),
    .io_in      (io_in),
    .io_out     (io_out),
    .io_out_stb (io_out_stb),
    .halted     (halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (!rst && io_out_stb) stb_cnt <= stb_cnt + 1;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  function automatic logic [15:0] val(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h0023;
      6: return 16'hFFE9;
      default: return 16'h1234;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[8'h82] = 16'hDEAD;
    mem[8'h83] = 16'hDEAD;
  endtask

  task automatic run_prog();
    int n;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    stb_cnt = 0;
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=halted");
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 halted", {15'd0, halted}, 16'h0000);
    chk("R1 mem_we", {15'd0, mem_we}, 16'h0000);
    chk("R1 stb", {15'd0, io_out_stb}, 16'h0000);
    chk("R1 io_out", {8'd0, io_out}, 16'h0000);
    chk("R1 mem_addr", {4'd0, mem_addr}, 16'h0000);

    // R3 R4: load/add/store and subtract sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        clear_mem();
        mem[0] = ins(4'h1, 12'h080);
        mem[1] = ins(4'h3, 12'h081);
        mem[2] = ins(4'h2, 12'h082);
        mem[3] = ins(4'h1, 12'h080);
        mem[4] = ins(4'h4, 12'h081);
        mem[5] = ins(4'h2, 12'h083);
        mem[6] = ins(4'h7, 12'h000);
        mem[8'h80] = val(i);
        mem[8'h81] = val(j);
        run_prog();
        chk("R4 add", mem[8'h82], val(i) + val(j));
        chk("R4 sub", mem[8'h83], val(i) - val(j));
      end
    end

    // R5 skip sweep over every selector
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [15:0] a;
        logic tk;
        a = val(i);
        clear_mem();
        mem[0] = ins(4'h1, 12'h080);
        mem[1] = ins(4'h8, 12'(c << 10));
        mem[2] = ins(4'h2, 12'h082);
        mem[3] = ins(4'h7, 12'h000);
        mem[8'h80] = a;
        run_prog();
        case (c)
          0: tk = a[15];
          1: tk = (a == 16'h0);
          2: tk = !a[15] && (a != 16'h0);
          default: tk = 1'b0;
        endcase
        chk("R5 skip", mem[8'h82], tk ? 16'hDEAD : a);
      end
    end

    // R7 indirect add
    for (int i = 0; i < 8; i++) begin
      clear_mem();
      mem[0] = ins(4'h1, 12'h080);
      mem[1] = ins(4'hB, 12'h081);
      mem[2] = ins(4'h2, 12'h082);
      mem[3] = ins(4'h7, 12'h000);
      mem[8'h80] = val(i);
      mem[8'h81] = 16'h0090;
      mem[8'h90] = val(7 - i);
      run_prog();
      chk("R7 addi", mem[8'h82], val(i) + val(7 - i));
    end

    // R9 input full sweep and clear
    for (int v = 0; v < 256; v++) begin
      clear_mem();
      io_in = 8'(v);
      mem[0] = ins(4'h1, 12'h080);
      mem[1] = ins(4'h5, 12'h000);
      mem[2] = ins(4'h2, 12'h082);
      mem[3] = ins(4'hA, 12'h000);
      mem[4] = ins(4'h2, 12'h083);
      mem[5] = ins(4'h7, 12'h000);
      mem[8'h80] = 16'hFFFF;
      run_prog();
      chk("R9 input", mem[8'h82], {8'h00, 8'(v)});
      chk("R9 clear", mem[8'h83], 16'h0000);
    end

    // R10 output value and single strobe
    for (int i = 0; i < 8; i++) begin
      clear_mem();
      mem[0] = ins(4'h1, 12'h080);
      mem[1] = ins(4'h6, 12'h000);
      mem[2] = ins(4'h7, 12'h000);
      mem[8'h80] = val(i) ^ 16'h00A5;
      run_prog();
      chk("R10 io_out", {8'h00, io_out}, {8'h00, val(i) [7:0] ^ 8'hA5});
      chk("R10 strobes", 16'(stb_cnt), 16'd1);
    end

    // R6 direct jump
    clear_mem();
    mem[0] = ins(4'h1, 12'h080);
    mem[1] = ins(4'h9, 12'h003);
    mem[2] = ins(4'h2, 12'h082);
    mem[3] = ins(4'h2, 12'h083);
    mem[4] = ins(4'h7, 12'h000);
    mem[8'h80] = 16'h3C3C;
    run_prog();
    chk("R6 jump skipped", mem[8'h82], 16'hDEAD);
    chk("R6 jump target", mem[8'h83], 16'h3C3C);

    // R6 indirect jump
    clear_mem();
    mem[0] = ins(4'h1, 12'h080);
    mem[1] = ins(4'hC, 12'h081);
    mem[2] = ins(4'h7, 12'h000);
    mem[8'h10] = ins(4'h2, 12'h082);
    mem[8'h11] = ins(4'h7, 12'h000);
    mem[8'h80] = 16'h4B4B;
    mem[8'h81] = 16'h0010;
    run_prog();
    chk("R6 jumpi", mem[8'h82], 16'h4B4B);

    // R8 jump-and-store with return through the saved word
    clear_mem();
    mem[0] = ins(4'h0, 12'h020);
    mem[1] = ins(4'h1, 12'h084);
    mem[2] = ins(4'h2, 12'h083);
    mem[3] = ins(4'h7, 12'h000);
    mem[8'h21] = ins(4'h1, 12'h020);
    mem[8'h22] = ins(4'h2, 12'h082);
    mem[8'h23] = ins(4'hC, 12'h020);
    mem[8'h84] = 16'h5A5A;
    run_prog();
    chk("R8 saved", mem[8'h20], 16'h0001);
    chk("R8 subr", mem[8'h82], 16'h0001);
    chk("R8 return", mem[8'h83], 16'h5A5A);

    // R12 undefined opcodes act as no-ops
    clear_mem();
    mem[0] = ins(4'h1, 12'h080);
    mem[1] = 16'hD081;
    mem[2] = 16'hE082;
    mem[3] = 16'hF083;
    mem[4] = ins(4'h2, 12'h082);
    mem[5] = ins(4'h7, 12'h000);
    mem[8'h80] = 16'h6E6E;
    mem[8'h81] = 16'h1111;
    run_prog();
    chk("R12 noop acc", mem[8'h82], 16'h6E6E);
    chk("R12 noop mem", mem[8'h83], 16'hDEAD);
    chk("R12 noop mem81", mem[8'h81], 16'h1111);

    // R11 halt stops everything
    clear_mem();
    mem[0] = ins(4'h1, 12'h080);
    mem[1] = ins(4'h7, 12'h000);
    mem[2] = ins(4'h2, 12'h082);
    mem[8'h80] = 16'h7777;
    run_prog();
    begin
      logic [11:0] a0;
      int bad;
      a0 = mem_addr;
      bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!halted || mem_we || mem_addr !== a0) bad++;
      end
      chk("R11 halted quiet", 16'(bad), 16'd0);
    end
    chk("R11 no later store", mem[8'h82], 16'hDEAD);

    // R4 stated example
    clear_mem();
    mem[0] = ins(4'h1, 12'h080);
    mem[1] = ins(4'h3, 12'h081);
    mem[2] = ins(4'h2, 12'h082);
    mem[3] = ins(4'h7, 12'h000);
    mem[8'h80] = 16'h0023;
    mem[8'h81] = 16'hFFE9;
    run_prog();
    chk("R4 R3 example", mem[8'h82], 16'h000C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule